// File: doc/BRIEF.md
# Triple Video FIFO Bank

This block buffers captured video words between a pixel-clock write domain and a bus-clock read domain. Three queues of 70, 35 and 35 words share one storage array. In planar mode each queue carries one component stream and runs on its own. In packed mode the whole array acts as a single 140-word queue. The write side has no back-pressure, because the video source cannot stall. Instead, each queue reports its fill level together with an early full flag and an almost-full flag, so the bus engine can react in time. A write into a queue that is physically full is refused and flagged.

The read side presents all three queues side by side. Each has its own valid/ready pair. A word leaves its queue on any read-clock edge where both valid and ready are high, whether the reader keeps that word or throws it away. Valid never drops until the head word is taken. Ready with valid low has no effect. All three queues can be drained in the same cycle. Pointers cross between the clock domains as Gray code through two-flop synchronisers. `packed_mode` is a static setting: it may be changed only while both domains are held in reset.

Top module: `tri_video_fifo`

## Requirements
- R1: After reset every fill count is 0, every full, almost-full and overflow flag is 0, and every `rd_valid` is 0.
- R2: In planar mode a write with `wr_valid` high goes to queue 0, 1 or 2 when `wr_lane` is 0, 1 or 2 respectively. The word is stored there and comes out in write order. A write with `wr_lane` equal to 3 is discarded.
- R3: `wr_fill[k]` gives the number of words held in queue k, as seen from the write domain. The planar capacities are 70, 35 and 35 words.
- R4: In planar mode `wr_afull[k]` is high exactly when the fill is 64 or more for queue 0, and 32 or more for queues 1 and 2.
- R5: In planar mode `wr_full[k]` is high exactly when the fill is 68 or more for queue 0, and 34 or more for queues 1 and 2. This is below the physical capacity.
- R6: A write to a queue whose fill equals its capacity is dropped. `wr_overflow[k]` is then high for exactly the one write-clock cycle after that edge, and the stored words are unchanged.
- R7: In packed mode every write goes to queue 0 whatever the value of `wr_lane`. Queue 0 holds 140 words and returns them in write order across the whole array. `rd_valid[1]` and `rd_valid[2]` stay 0 and their `rd_ready` has no effect.
- R8: In packed mode queue 0 raises almost-full at a fill of 128 or more, and full at 136 or more.
- R9: `rd_valid[k]` is high while queue k is non-empty, and it stays high until the word is taken. A word is removed on each read edge with both valid and ready high, and the three queues may be popped in the same cycle. Ready with valid low has no effect.
- R10: A word written at a write edge is visible on `rd_valid` no later than the third read-clock edge after that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| packed_mode | input | 1 | 1 merges the array into one queue; static between resets |
| wr_valid | input | 1 | Write strobe for one word |
| wr_lane | input | 2 | Target queue in planar mode (3 = none) |
| wr_data | input | 16 | Word to store |
| wr_fill | output | 3x8 | Per-queue fill count, write domain |
| wr_afull | output | 3 | Per-queue almost-full flag |
| wr_full | output | 3 | Per-queue early full flag |
| wr_overflow | output | 3 | One-cycle pulse per dropped write |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_ready | input | 3 | Per-queue pop or discard request |
| rd_valid | output | 3 | Per-queue head word present |
| rd_data | output | 3x16 | Per-queue head word |

## Verification
The functions that can coincide are a write into one queue and pops on the other queues in the same clock cycle, together with pops of two or three queues at once. The bench provokes this by first filling the three queues in the densest interleaved order. It then pops queues 0 and 1 together in a concurrent thread while another thread keeps writing to queue 2. Every word leaving each queue is compared against that queue's own expected sequence, and queue 2 is then drained to show that no write was lost or misplaced while the other queues were being emptied.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
  typedef struct packed {
    logic [15:0] depth;
    logic [15:0] base;
    logic [15:0] full_thr;
    logic [15:0] afull_thr;
  } lane_cfg_t;

  function automatic logic [15:0] to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] from_gray(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/tvf_sync.sv
module tvf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tvf_wr_lane.sv
module tvf_wr_lane
  import tvf_pkg::*;
#(
  parameter int PW = 9,
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  lane_cfg_t     cfg,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          afull,
  output logic          overflow
);
  logic [PW-1:0] wbin, rbin, diff;
  logic [AW-1:0] waddr;
  logic          room;

  assign rbin      = PW'(from_gray(16'(rgray_s)));
  assign diff      = wbin - rbin;
  assign fill      = CW'(diff);
  assign room      = 16'(diff) < cfg.depth;
  assign full      = 16'(diff) >= cfg.full_thr;
  assign afull     = 16'(diff) >= cfg.afull_thr;
  assign mem_we    = wr_en && room;
  assign mem_waddr = AW'(cfg.base) + waddr;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      waddr    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= wr_en && !room;
      if (mem_we) begin
        wbin  <= wbin + 1'b1;
        wgray <= PW'(to_gray(16'(wbin + 1'b1)));
        waddr <= (16'(waddr) + 16'd1 >= cfg.depth) ? '0 : waddr + 1'b1;
      end
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    16'(diff) <= cfg.depth);

  // R6
  overflow_cause_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    overflow |-> $past(wr_en && !room));
endmodule

// File: rtl/tvf_rd_lane.sv
module tvf_rd_lane
  import tvf_pkg::*;
#(
  parameter int PW = 9,
  parameter int AW = 8
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  lane_cfg_t     cfg,
  input  logic          lane_on,
  input  logic [PW-1:0] wgray_s,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] mem_raddr
);
  logic [PW-1:0] rbin, wbin;
  logic [AW-1:0] raddr;
  logic          pop;

  assign wbin      = PW'(from_gray(16'(wgray_s)));
  assign rd_valid  = lane_on && (wbin != rbin);
  assign pop       = rd_valid && rd_ready;
  assign mem_raddr = AW'(cfg.base) + raddr;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      raddr <= '0;
    end else if (pop) begin
      rbin  <= rbin + 1'b1;
      rgray <= PW'(to_gray(16'(rbin + 1'b1)));
      raddr <= (16'(raddr) + 16'd1 >= cfg.depth) ? '0 : raddr + 1'b1;
    end
  end

  // R9
  hold_valid_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  // R10
  gray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(wgray_s ^ $past(wgray_s)) <= 1);
endmodule

// File: rtl/tri_video_fifo.sv
module tri_video_fifo
  import tvf_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DEPTH0 = 70,
  parameter int DEPTH1 = 35,
  parameter int DEPTH2 = 35,
  parameter int FULL0  = 68,
  parameter int FULL1  = 34,
  parameter int FULL2  = 34,
  parameter int AFULL0 = 64,
  parameter int AFULL1 = 32,
  parameter int AFULL2 = 32,
  localparam int LANES = 3,
  localparam int TOTAL = DEPTH0 + DEPTH1 + DEPTH2,
  localparam int CW    = $clog2(TOTAL + 1),
  localparam int AW    = $clog2(TOTAL),
  localparam int PW    = $clog2(TOTAL + 1) + 1
) (
  input  logic                      wclk,
  input  logic                      wrst_n,
  input  logic                      packed_mode,
  input  logic                      wr_valid,
  input  logic [1:0]                wr_lane,
  input  logic [DW-1:0]             wr_data,
  output logic [LANES-1:0][CW-1:0]  wr_fill,
  output logic [LANES-1:0]          wr_afull,
  output logic [LANES-1:0]          wr_full,
  output logic [LANES-1:0]          wr_overflow,
  input  logic                      rclk,
  input  logic                      rrst_n,
  input  logic [LANES-1:0]          rd_ready,
  output logic [LANES-1:0]          rd_valid,
  output logic [LANES-1:0][DW-1:0]  rd_data
);
  localparam int DEP  [LANES] = '{DEPTH0, DEPTH1, DEPTH2};
  localparam int BASE [LANES] = '{0, DEPTH0, DEPTH0 + DEPTH1};
  localparam int FTHR [LANES] = '{FULL0, FULL1, FULL2};
  localparam int ATHR [LANES] = '{AFULL0, AFULL1, AFULL2};
  localparam int P_FULL  = FULL0 + FULL1 + FULL2;
  localparam int P_AFULL = AFULL0 + AFULL1 + AFULL2;

  logic [DW-1:0]   mem [TOTAL];
  logic [LANES-1:0] mem_we;
  logic [AW-1:0]   mem_waddr [LANES];
  logic [AW-1:0]   mem_raddr [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_cfg_t     cfg;
    logic          lane_on, wen;
    logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;

    always_comb begin
      if (packed_mode && k == 0)
        cfg = '{depth: 16'(TOTAL), base: 16'd0,
                full_thr: 16'(P_FULL), afull_thr: 16'(P_AFULL)};
      else
        cfg = '{depth: 16'(DEP[k]), base: 16'(BASE[k]),
                full_thr: 16'(FTHR[k]), afull_thr: 16'(ATHR[k])};
    end

    assign lane_on = !packed_mode || (k == 0);
    assign wen     = wr_valid && lane_on && (packed_mode || wr_lane == 2'(k));

    tvf_wr_lane #(.PW(PW), .AW(AW), .CW(CW)) u_wr (
      .wclk(wclk), .wrst_n(wrst_n), .cfg(cfg), .wr_en(wen),
      .rgray_s(rgray_s), .wgray(wgray), .mem_we(mem_we[k]),
      .mem_waddr(mem_waddr[k]), .fill(wr_fill[k]), .full(wr_full[k]),
      .afull(wr_afull[k]), .overflow(wr_overflow[k])
    );

    tvf_sync #(.W(PW)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    tvf_sync #(.W(PW)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    tvf_rd_lane #(.PW(PW), .AW(AW)) u_rd (
      .rclk(rclk), .rrst_n(rrst_n), .cfg(cfg), .lane_on(lane_on),
      .wgray_s(wgray_s), .rd_ready(rd_ready[k]), .rd_valid(rd_valid[k]),
      .rgray(rgray), .mem_raddr(mem_raddr[k])
    );

    assign rd_data[k] = mem[mem_raddr[k]];
  end

  always_ff @(posedge wclk) begin
    for (int k = 0; k < LANES; k++)
      if (mem_we[k]) mem[mem_waddr[k]] <= wr_data;
  end

  // R5
  full_implies_afull_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_full & ~wr_afull) == '0);
endmodule

// File: tb/tri_video_fifo_test.sv
module tri_video_fifo_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             wrst_n, rrst_n, packed_mode, wr_valid;
  logic [1:0]       wr_lane;
  logic [15:0]      wr_data;
  logic [2:0][7:0]  wr_fill;
  logic [2:0]       wr_afull, wr_full, wr_overflow, rd_ready, rd_valid;
  logic [2:0][15:0] rd_data;

  int total = 0;
  int fails = 0;
  int ovf_cnt [3];

  tri_video_fifo uut (
    .wclk(clk), .wrst_n(wrst_n), .packed_mode(packed_mode),
    .wr_valid(wr_valid), .wr_lane(wr_lane), .wr_data(wr_data),
    .wr_fill(wr_fill), .wr_afull(wr_afull), .wr_full(wr_full),
    .wr_overflow(wr_overflow), .rclk(clk), .rrst_n(rrst_n),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {mode, lane, words, exp_afull, exp_full}
  localparam logic [12:0] VEC [11] = '{
    {1'b0, 2'd0, 8'd63,  1'b0, 1'b0},
    {1'b0, 2'd0, 8'd64,  1'b1, 1'b0},
    {1'b0, 2'd0, 8'd68,  1'b1, 1'b1},
    {1'b0, 2'd1, 8'd31,  1'b0, 1'b0},
    {1'b0, 2'd1, 8'd32,  1'b1, 1'b0},
    {1'b0, 2'd2, 8'd34,  1'b1, 1'b1},
    {1'b0, 2'd2, 8'd35,  1'b1, 1'b1},
    {1'b1, 2'd0, 8'd127, 1'b0, 1'b0},
    {1'b1, 2'd0, 8'd128, 1'b1, 1'b0},
    {1'b1, 2'd0, 8'd136, 1'b1, 1'b1},
    {1'b1, 2'd2, 8'd140, 1'b1, 1'b1}
  };

  always @(negedge clk)
    for (int k = 0; k < 3; k++) if (wr_overflow[k]) ovf_cnt[k]++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic do_reset(input logic mode);
    wrst_n = 1'b0; rrst_n = 1'b0; wr_valid = 1'b0; wr_lane = '0;
    wr_data = '0; rd_ready = '0; packed_mode = mode;
    repeat (3) @(posedge clk);
    #1 wrst_n = 1'b1; rrst_n = 1'b1;
    for (int k = 0; k < 3; k++) ovf_cnt[k] = 0;
  endtask

  task automatic wr_word(input int ln, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_lane = 2'(ln); wr_data = 16'(d);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic pop(input int ln, input int exp, input string req);
    @(negedge clk);
    chk(req, int'(rd_valid[ln]), 1);
    chk(req, int'(rd_data[ln]), exp);
    rd_ready[ln] = 1'b1;
    @(posedge clk);
    #1 rd_ready[ln] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    do_reset(1'b0);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R1 fill", int'(wr_fill[k]), 0);
      chk("R1 afull", int'(wr_afull[k]), 0);
      chk("R1 full", int'(wr_full[k]), 0);
      chk("R1 overflow", int'(wr_overflow[k]), 0);
      chk("R1 valid", int'(rd_valid[k]), 0);
    end

    // R3 R4 R5 R7 R8: threshold vectors, then drain in order
    for (int v = 0; v < 11; v++) begin
      logic md; int ln, n, idx;
      md = VEC[v][12]; ln = int'(VEC[v][11:10]); n = int'(VEC[v][9:2]);
      idx = md ? 0 : ln;
      do_reset(md);
      for (int i = 0; i < n; i++) wr_word(ln, (idx << 14) | i);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(md ? "R7 fill" : "R3 fill", int'(wr_fill[idx]), n);
      chk(md ? "R8 afull" : "R4 afull", int'(wr_afull[idx]), int'(VEC[v][1]));
      chk(md ? "R8 full" : "R5 full", int'(wr_full[idx]), int'(VEC[v][0]));
      chk("R6 no overflow", ovf_cnt[idx], 0);
      if (md) begin
        rd_ready[2:1] = 2'b11;
        chk("R7 lanes idle", int'(rd_valid[2:1]), 0);
        repeat (3) @(posedge clk);
        #1 rd_ready[2:1] = 2'b00;
        @(negedge clk);
        chk("R7 fill kept", int'(wr_fill[0]), n);
      end
      for (int i = 0; i < n; i++)
        pop(idx, (idx << 14) | i, md ? "R7 order" : "R2 order");
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R9 empty", int'(rd_valid[idx]), 0);
      chk("R3 drained fill", int'(wr_fill[idx]), 0);
    end

    // R2: lane 3 discarded in planar mode
    do_reset(1'b0);
    wr_word(3, 16'h1234);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 lane3 valid", int'(rd_valid), 0);
    chk("R2 lane3 fill", int'(wr_fill[0]) + int'(wr_fill[1]) + int'(wr_fill[2]), 0);

    // R10: visibility latency
    do_reset(1'b0);
    wr_word(1, 16'h0abc);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 latency", int'(rd_valid[1]), 1);
    chk("R10 data", int'(rd_data[1]), 16'h0abc);

    // R9: ready without valid on an empty lane has no effect
    rd_ready[2] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rd_ready[2] = 1'b0;
    wr_word(2, 16'h0777);
    repeat (4) @(posedge clk);
    pop(2, 16'h0777, "R9 idle ready");

    // R6: overflow on a full lane
    do_reset(1'b0);
    for (int i = 0; i < 36; i++) wr_word(2, (2 << 14) | i);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 overflow count", ovf_cnt[2], 1);
    chk("R6 other lanes", ovf_cnt[0] + ovf_cnt[1], 0);
    chk("R6 fill capped", int'(wr_fill[2]), 35);
    for (int i = 0; i < 35; i++) pop(2, (2 << 14) | i, "R6 data intact");

    // R9: densest write pattern, then concurrent pops and writes
    do_reset(1'b0);
    begin
      int c0, c1, c2;
      c0 = 0; c1 = 0; c2 = 0;
      for (int r = 0; r < 8; r++) begin
        wr_word(0, c0); c0++;
        wr_word(1, (1 << 14) | c1); c1++;
        wr_word(0, c0); c0++;
        wr_word(2, (2 << 14) | c2); c2++;
      end
      repeat (4) @(posedge clk);
      fork
        begin
          for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 dual valid", int'(rd_valid[1:0]), 3);
            chk("R9 dual lane0", int'(rd_data[0]), i);
            chk("R9 dual lane1", int'(rd_data[1]), (1 << 14) | i);
            rd_ready[1:0] = 2'b11;
            @(posedge clk);
            #1 rd_ready[1:0] = 2'b00;
          end
        end
        begin
          for (int i = 8; i < 16; i++) wr_word(2, (2 << 14) | i);
        end
      join
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R9 lane1 empty", int'(rd_valid[1]), 0);
      chk("R3 lane2 fill", int'(wr_fill[2]), 16);
      // all three popped together
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk("R9 triple lane0", int'(rd_data[0]), 8 + i);
        chk("R9 triple lane2", int'(rd_data[2]), (2 << 14) | i);
        rd_ready = 3'b111;
        @(posedge clk);
        #1 rd_ready = 3'b000;
      end
      for (int i = 8; i < 16; i++) pop(2, (2 << 14) | i, "R9 lane2 tail");
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R9 all empty", int'(rd_valid), 0);
    end

    summary();
  end
endmodule